// File: doc/BRIEF.md
# UART Receive Idle Timeout Detector

This block sits beside the receive side of a UART that can run either with a single receive holding buffer or with a receive FIFO. It tells software when received data has been left unread for too long while no further characters arrive on the line. The detector counts bit periods on a single-cycle baud tick. It restarts the count on every received character and holds the count at zero while no data is waiting. When the count reaches a limit derived from the programmed word length, it raises a sticky status bit.

The timeout limit is four bit periods per word-length unit plus twelve. The word-length unit is the number of data bits, so the limit tracks the length of a character frame. Software clears the status bit by writing a one to it. An interrupt request follows the status bit whenever the interrupt enable is set. The serial receiver, the FIFO storage and the register interface sit outside the block.

Top module: `rx_idle_timeout`

## Requirements
- R1: After a synchronous active-low reset, `to_status` and `to_irq` are 0.
- R2: The `wlen_sel` code selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. The limit is then 32, 36, 40 or 44 ticks. Counting starts at the last received character, or at the point data became pending. `to_status` is 1 at the clock edge that samples the limit-th tick and is 0 after one tick fewer.
- R3: The count advances only in cycles where `baud_tick` is 1. Any number of cycles without a tick never sets `to_status`.
- R4: A `char_rcvd` pulse restarts the count from zero.
- R5: Pending data is `fifo_valid` when `fifo_mode` is 1 and `buf_valid` when it is 0. The unselected level is ignored. While nothing is pending, the count is held at zero and `to_status` never sets.
- R6: `to_status` is sticky. After a timeout, the counter stops until the next `char_rcvd` or until pending data drains. Clearing the status while the same data still waits does not set it again.
- R7: A write strobe `clr_wr` with `clr_data` = 1 clears `to_status` on the next edge. With `clr_data` = 0 the strobe has no effect.
- R8: When a timeout and a write-one-to-clear fall in the same cycle, `to_status` ends up 1.
- R9: `to_irq` equals `to_status` AND `irq_en` in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wlen_sel | input | 2 | Word length code: 0..3 selects 5..8 data bits |
| fifo_mode | input | 1 | 1 selects FIFO operation, 0 selects the single buffer |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| char_rcvd | input | 1 | One-cycle pulse when a character has been received |
| buf_valid | input | 1 | Holding buffer holds unread data (non-FIFO operation) |
| fifo_valid | input | 1 | Receive FIFO is not empty (FIFO operation) |
| clr_wr | input | 1 | Status register write strobe |
| clr_data | input | 1 | Value written to the timeout status bit position |
| irq_en | input | 1 | Timeout interrupt enable |
| to_status | output | 1 | Sticky timeout status |
| to_irq | output | 1 | Timeout interrupt request |

## Verification
The timeout sets `to_status` on the same clock edge that samples the limit-th `baud_tick`, so the status is due one edge after that tick is driven. A write-one-to-clear is likewise due one edge after its strobe. `to_irq` changes within the cycle in which `irq_en` or `to_status` changes. The bench drives every input just after a falling edge and reads outputs just before the next falling edge. Each result is therefore read after exactly the edge that should produce it. The bench compares the status after limit-1 and after limit ticks, which pins the count to the exact tick.

// File: rtl/rxto_pkg.sv
// Package: shared sizing constants and timeout length arithmetic for the
// receive idle timeout detector.
// Assumes: word length code is a small unsigned offset from BASE_DBITS.
package rxto_pkg;
    localparam int WLEN_W     = 2;   // width of the word-length code
    localparam int BASE_DBITS = 5;   // data bits for code 0
    localparam int PER_BIT    = 4;   // bit periods per data bit
    localparam int EXTRA      = 12;  // fixed bit periods added

    // Timeout length in bit periods for a given word-length code.
    function automatic int timeout_len(input int code, input int base,
                                       input int per, input int extra);
        return (base + code) * per + extra;
    endfunction
endpackage

// File: rtl/rxto_limit.sv
// Module: rxto_limit
// Turns the word-length code into a tick limit. One constant per code is
// built by a generate loop; the code then picks one of them.
// Assumes: CNT_W holds the largest limit.
module rxto_limit #(
    parameter int WLEN_W     = 2,
    parameter int BASE_DBITS = 5,
    parameter int PER_BIT    = 4,
    parameter int EXTRA      = 12,
    parameter int CNT_W      = 6
) (
    input  logic [WLEN_W-1:0] wlen_sel,
    output logic [CNT_W-1:0]  limit
);
    localparam int NCODES = 2 ** WLEN_W;

    logic [CNT_W-1:0] lim_tab [NCODES];

    // One constant limit per word-length code.
    for (genvar g = 0; g < NCODES; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'(rxto_pkg::timeout_len(g, BASE_DBITS, PER_BIT, EXTRA));
    end

    // Select the limit for the programmed code.
    always_comb limit = lim_tab[wlen_sel];
endmodule

// File: rtl/rxto_counter.sv
// Module: rxto_counter
// Counts baud ticks while data is pending and no new character arrives.
// Pulses hit once when the count reaches the limit, then freezes until a
// character arrives or the data drains.
// Assumes: baud_tick and char_rcvd are single-cycle pulses.
module rxto_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending,
    input  logic             char_rcvd,
    input  logic             baud_tick,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;
    logic             done;

    // Timeout event: this tick is the limit-th one since the restart.
    always_comb hit = pending && !char_rcvd && !done && baud_tick
                      && (cnt >= limit - CNT_W'(1));

    // Tick counter with restart, hold and freeze-after-timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!pending || char_rcvd) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (hit) begin
            cnt  <= limit;
            done <= 1'b1;
        end else if (baud_tick && !done) begin
            cnt  <= cnt + CNT_W'(1);
        end
    end

    // R5: with nothing pending last cycle the count is back at zero.
    assert_hold_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pending) |-> (cnt == '0 && !done));

    // R6: once frozen, the count does not move while the data still waits.
    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pending && !char_rcvd) |=> $stable(cnt));

    // R6: a timeout cannot repeat while the counter is frozen.
    assert_single_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/rxto_status.sv
// Module: rxto_status
// Sticky status bit, set by the timeout event and cleared by writing one.
// A set in the same cycle as a clear takes priority.
// Assumes: clr_wr is a single-cycle strobe from the register interface.
module rxto_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_wr,
    input  logic clr_data,
    output logic status
);
    logic clr_req;

    // A write clears only when a one lands on the bit.
    always_comb clr_req = clr_wr && clr_data;

    // Sticky status register, set before clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       status <= 1'b0;
        else if (set_evt) status <= 1'b1;
        else if (clr_req) status <= 1'b0;
    end

    // R7: a one written with no coincident set clears the bit.
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data && !set_evt) |=> !status);

    // R7: a zero written leaves a set bit alone.
    assert_w0_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status && clr_wr && !clr_data) |=> status);

    // R8: a set wins over a coincident clear.
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && clr_wr && clr_data) |=> status);

    // R6: without a clearing write the bit stays set.
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !(clr_wr && clr_data)) |=> status);
endmodule

// File: rtl/rx_idle_timeout.sv
// Module: rx_idle_timeout (top)
// Receive idle timeout detector. Picks the pending-data source by mode,
// derives the limit from the word length, counts ticks and holds a sticky
// status with a gated interrupt request.
// Assumes: inputs are synchronous to clk.
module rx_idle_timeout #(
    parameter int WLEN_W     = rxto_pkg::WLEN_W,
    parameter int BASE_DBITS = rxto_pkg::BASE_DBITS,
    parameter int PER_BIT    = rxto_pkg::PER_BIT,
    parameter int EXTRA      = rxto_pkg::EXTRA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WLEN_W-1:0] wlen_sel,
    input  logic              fifo_mode,
    input  logic              baud_tick,
    input  logic              char_rcvd,
    input  logic              buf_valid,
    input  logic              fifo_valid,
    input  logic              clr_wr,
    input  logic              clr_data,
    input  logic              irq_en,
    output logic              to_status,
    output logic              to_irq
);
    localparam int MAX_LIM = rxto_pkg::timeout_len(2 ** WLEN_W - 1, BASE_DBITS, PER_BIT, EXTRA);
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    logic             pending;
    logic [CNT_W-1:0] limit;
    logic             hit;

    // Pick the pending-data source for the current mode.
    always_comb pending = fifo_mode ? fifo_valid : buf_valid;

    rxto_limit #(
        .WLEN_W(WLEN_W), .BASE_DBITS(BASE_DBITS), .PER_BIT(PER_BIT),
        .EXTRA(EXTRA), .CNT_W(CNT_W)
    ) u_limit (
        .wlen_sel (wlen_sel),
        .limit    (limit)
    );

    rxto_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .char_rcvd (char_rcvd),
        .baud_tick (baud_tick),
        .limit     (limit),
        .hit       (hit)
    );

    rxto_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (hit),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .status   (to_status)
    );

    // Interrupt request follows the status when enabled.
    always_comb to_irq = to_status && irq_en;

    // R2/R3/R5: a rising status needs a tick on pending data with no new character.
    assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_status) |-> $past(pending && baud_tick && !char_rcvd));
endmodule

// File: tb/rx_idle_timeout_test.sv
module rx_idle_timeout_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] wlen_sel = 2'd0;
    logic       fifo_mode = 1'b0, baud_tick = 1'b0, char_rcvd = 1'b0;
    logic       buf_valid = 1'b0, fifo_valid = 1'b0;
    logic       clr_wr = 1'b0, clr_data = 1'b0, irq_en = 1'b0;
    logic       to_status, to_irq;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #5 clk = ~clk;

    rx_idle_timeout uut (
        .clk(clk), .rst_n(rst_n), .wlen_sel(wlen_sel), .fifo_mode(fifo_mode),
        .baud_tick(baud_tick), .char_rcvd(char_rcvd), .buf_valid(buf_valid),
        .fifo_valid(fifo_valid), .clr_wr(clr_wr), .clr_data(clr_data),
        .irq_en(irq_en), .to_status(to_status), .to_irq(to_irq)
    );

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d exp=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) baud_tick = 1'b1;
            @(negedge clk) baud_tick = 1'b0;
        end
    endtask

    task automatic rx_char();
        @(negedge clk) char_rcvd = 1'b1;
        @(negedge clk) char_rcvd = 1'b0;
    endtask

    task automatic wr(input logic d);
        @(negedge clk) begin clr_wr = 1'b1; clr_data = d; end
        @(negedge clk) begin clr_wr = 1'b0; clr_data = 1'b0; end
    endtask

    task automatic drain_clear();
        @(negedge clk) begin buf_valid = 1'b0; fifo_valid = 1'b0; end
        wr(1'b1);
    endtask

    // Vector: {fifo_mode, wlen_sel[1:0], tick count[5:0], expected status}
    localparam int NV = 8;
    localparam logic [9:0] VEC [NV] = '{
        {1'b0, 2'd0, 6'd31, 1'b0}, {1'b1, 2'd0, 6'd32, 1'b1},
        {1'b1, 2'd1, 6'd35, 1'b0}, {1'b0, 2'd1, 6'd36, 1'b1},
        {1'b0, 2'd2, 6'd39, 1'b0}, {1'b1, 2'd2, 6'd40, 1'b1},
        {1'b1, 2'd3, 6'd43, 1'b0}, {1'b0, 2'd3, 6'd44, 1'b1}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 status after reset", to_status, 1'b0);
        check("R1 irq after reset", to_irq, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // R2: table walk over word lengths and both modes
        irq_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            drain_clear();
            @(negedge clk) begin
                fifo_mode = VEC[v][9];
                wlen_sel  = VEC[v][8:7];
                if (VEC[v][9]) fifo_valid = 1'b1; else buf_valid = 1'b1;
            end
            rx_char();
            ticks(int'(VEC[v][6:1]));
            check("R2 timeout length", to_status, VEC[v][0]);
            check("R9 irq with enable", to_irq, VEC[v][0]);
        end

        // R3: no ticks, no timeout
        drain_clear();
        @(negedge clk) begin fifo_mode = 1'b0; wlen_sel = 2'd0; buf_valid = 1'b1; end
        rx_char();
        repeat (200) @(negedge clk);
        check("R3 no tick no count", to_status, 1'b0);

        // R4: restart on a new character
        ticks(20);
        rx_char();
        ticks(20);
        check("R4 restart before limit", to_status, 1'b0);
        ticks(12);
        check("R4 limit after restart", to_status, 1'b1);

        // R5: unselected source ignored, nothing pending
        drain_clear();
        @(negedge clk) begin fifo_mode = 1'b0; fifo_valid = 1'b1; end
        rx_char();
        ticks(50);
        check("R5 fifo level ignored in buffer mode", to_status, 1'b0);
        @(negedge clk) begin fifo_mode = 1'b1; fifo_valid = 1'b0; buf_valid = 1'b1; end
        ticks(50);
        check("R5 buffer level ignored in fifo mode", to_status, 1'b0);
        // drain mid-count resets count
        @(negedge clk) fifo_valid = 1'b1;
        ticks(30);
        @(negedge clk) fifo_valid = 1'b0;
        @(negedge clk) fifo_valid = 1'b1;
        ticks(31);
        check("R5 drain resets count", to_status, 1'b0);
        ticks(1);
        check("R5 count from pending start", to_status, 1'b1);

        // R7: write zero keeps, write one clears
        wr(1'b0);
        check("R7 write zero no effect", to_status, 1'b1);
        wr(1'b1);
        check("R7 write one clears", to_status, 1'b0);

        // R6: no re-set while the same data waits
        ticks(100);
        check("R6 frozen after timeout", to_status, 1'b0);
        rx_char();
        ticks(32);
        check("R6 sets again after character", to_status, 1'b1);

        // R8: set wins over a coincident clear
        rx_char();
        ticks(31);
        @(negedge clk) begin baud_tick = 1'b1; clr_wr = 1'b1; clr_data = 1'b1; end
        @(negedge clk) begin baud_tick = 1'b0; clr_wr = 1'b0; clr_data = 1'b0; end
        check("R8 set wins", to_status, 1'b1);

        // R9: irq follows enable in the same cycle
        @(negedge clk) irq_en = 1'b0;
        #1 check("R9 irq masked", to_irq, 1'b0);
        irq_en = 1'b1;
        #1 check("R9 irq unmasked", to_irq, 1'b1);
        wr(1'b1);
        check("R9 irq drops with status", to_irq, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule